// File: doc/BRIEF.md
# Software-Managed Set-Associative Translation Buffer

This block holds a joint translation table of page descriptors in a set-associative array of 128 sets by 2 or 4 ways. It never looks up or refills on its own. Software drives it through four registers behind one write port: a tag descriptor (virtual page number, present bit, global bit, 8-bit address-space ID), a frame descriptor (physical frame and permissions, stored opaquely), an index register and a command register. Each command is a single register write. Its results (index or descriptors) can be read on the outputs in the cycle after the write.

Commands include several operations. Probe, free-slot selection and the associative insert and delete work on the set chosen by the tag descriptor. Index-addressed write and read work on one entry. A separate command clears the micro-TLBs. Where the cached contents of the micro-TLBs could go stale, the block pulses a one-cycle invalidate strobe to them.

Top module: `swtlb_ctrl`

## Requirements
- R1: The linear entry index is set × ways + way. The set is taken from tag-descriptor bits [19:13], the low bits of the virtual page number held in bits [31:13]. Index-addressed commands use the low log2(entries) bits of the index register.
- R2: A probe that matches exactly one way loads that way's linear index into the index register with bit 31 clear.
- R3: A probe that matches no way loads 32'h8000_0000. Bit 31 is the lookup-error flag.
- R4: A probe that matches two or more ways loads the duplicate code 32'h C000_0000. This code also has bit 31 set.
- R5: A stored entry matches when all of these hold: its present bit (bit 10) is set, its page number equals the descriptor's, and either its global bit (bit 8) is set or its ASID (bits [7:0]) equals the descriptor's.
- R6: Free-slot selection (command 3) loads the index of the lowest-numbered way in the addressed set whose present bit is clear. If every way is present, it uses a round-robin way pointer, which then advances by one.
- R7: Write (command 1) stores both descriptors at the index and pulses the invalidate strobe in the next cycle. An all-zero descriptor pair written this way blanks the slot.
- R8: Write without invalidate (command 5) stores the same way but leaves the strobe low.
- R9: Command 6 pulses the strobe and changes no register or entry.
- R10: Read (command 2) loads the entry at the index into both descriptor registers.
- R11: Insert (command 7) behaves as follows. If an entry matches, it overwrites the lowest matching way. If none matches, it uses the slot rule of R6. In both cases it loads the used index and pulses the strobe.
- R12: Delete (command 8) zeroes every matching way of the addressed set and pulses the strobe. The index register is left unchanged.
- R13: Register select 0/1/2/3 picks tag descriptor, frame descriptor, index and command. Command codes outside 1..8 change nothing. The busy output stays low.
- R14: After reset, all registers are zero, every entry is blank and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 tag, 1 frame, 2 index, 3 command) |
| reg_wdata_i | input | 32 | Write data; command code in bits [3:0] |
| tag_desc_o | output | 32 | Tag descriptor register |
| frm_desc_o | output | 32 | Frame descriptor register |
| index_o | output | 32 | Index register with error codes |
| uinv_o | output | 1 | One-cycle micro-TLB invalidate strobe |
| busy_o | output | 1 | Always low; no command stalls |

## Verification
The duplicate-hit code is the hardest case to reach, because insert never creates a second copy of a tag. The bench reaches it with index-addressed writes that place one tag into two ways of a set, then probes that set and checks the duplicate code. It also checks that a single delete clears both copies. Round-robin eviction needs a full set. Four inserts with page numbers 128 apart fill one set, and further inserts and free-slot requests then step the victim pointer. A random phase then runs commands on five tags that share one set, and compares against the reference model on every clock.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  localparam int DESC_W   = 32;
  localparam int PAGE_LSB = 13;
  localparam int PRES_BIT = 10;
  localparam int GLOB_BIT = 8;
  localparam int ASID_W   = 8;

  localparam logic [DESC_W-1:0] IDX_MISS = 32'h8000_0000;
  localparam logic [DESC_W-1:0] IDX_DUP  = 32'hC000_0000;

  localparam logic [1:0] SEL_TAG = 2'd0;
  localparam logic [1:0] SEL_FRM = 2'd1;
  localparam logic [1:0] SEL_IDX = 2'd2;
  localparam logic [1:0] SEL_CMD = 2'd3;

  typedef enum logic [3:0] {
    CMD_WRITE    = 4'd1,
    CMD_READ     = 4'd2,
    CMD_FREE     = 4'd3,
    CMD_PROBE    = 4'd4,
    CMD_WRITE_NI = 4'd5,
    CMD_UINV     = 4'd6,
    CMD_INSERT   = 4'd7,
    CMD_DELETE   = 4'd8
  } tlb_cmd_e;

  typedef struct packed {
    logic [DESC_W-1:0] tag;
    logic [DESC_W-1:0] frm;
  } tlb_entry_t;

  // stored entry against lookup key: present, same page, global or same ASID
  function automatic logic tag_hits(logic [DESC_W-1:0] stored, logic [DESC_W-1:0] key);
    return stored[PRES_BIT]
        && (stored[DESC_W-1:PAGE_LSB] == key[DESC_W-1:PAGE_LSB])
        && (stored[GLOB_BIT] || (stored[ASID_W-1:0] == key[ASID_W-1:0]));
  endfunction

  // row-major linear position of (set, way)
  function automatic int unsigned lin_index(int unsigned set, int unsigned way, int unsigned ways);
    return set * ways + way;
  endfunction
endpackage

// File: rtl/swtlb_way_cmp.sv
module swtlb_way_cmp
  import swtlb_pkg::*;
#(
  parameter int NUM_WAYS = 4
) (
  input  logic [NUM_WAYS-1:0][DESC_W-1:0] tags_i,
  input  logic [DESC_W-1:0]               key_i,
  output logic [NUM_WAYS-1:0]             hit_o,
  output logic [NUM_WAYS-1:0]             valid_o
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hit_o[w]   = tag_hits(tags_i[w], key_i);
    assign valid_o[w] = tags_i[w][PRES_BIT];
  end
endmodule

// File: rtl/swtlb_slot_pick.sv
module swtlb_slot_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [NUM_WAYS-1:0] hit_i,
  input  logic [WAY_W-1:0]    rr_i,
  output logic [WAY_W-1:0]    slot_way_o,
  output logic                full_o,
  output logic [WAY_W-1:0]    hit_way_o,
  output logic                any_hit_o
);
  logic [WAY_W-1:0] low_free;

  always_comb begin
    low_free  = '0;
    hit_way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) low_free  = WAY_W'(w);
      if (hit_i[w])    hit_way_o = WAY_W'(w);
    end
  end

  assign full_o     = &valid_i;
  assign any_hit_o  = |hit_i;
  assign slot_way_o = full_o ? rr_i : low_free;
endmodule

// File: rtl/swtlb_ctrl.sv
module swtlb_ctrl
  import swtlb_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DESC_W-1:0] reg_wdata_i,
  output logic [DESC_W-1:0] tag_desc_o,
  output logic [DESC_W-1:0] frm_desc_o,
  output logic [DESC_W-1:0] index_o,
  output logic              uinv_o,
  output logic              busy_o
);
  localparam int SET_W   = $clog2(NUM_SETS);
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int ENTRIES = NUM_SETS * NUM_WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [DESC_W-1:0] tag_q, frm_q, idx_q;
  logic              uinv_q;
  logic [WAY_W-1:0]  rr_q;
  tlb_entry_t        mem [ENTRIES];

  // decoded command events
  logic     cmd_fire;
  tlb_cmd_e cmd_code;
  logic     do_write, do_write_ni, do_read, do_free, do_probe, do_uinv, do_insert, do_delete;

  assign cmd_fire    = reg_wr_i && (reg_sel_i == SEL_CMD);
  assign cmd_code    = tlb_cmd_e'(reg_wdata_i[3:0]);
  assign do_write    = cmd_fire && (cmd_code == CMD_WRITE);
  assign do_write_ni = cmd_fire && (cmd_code == CMD_WRITE_NI);
  assign do_read     = cmd_fire && (cmd_code == CMD_READ);
  assign do_free     = cmd_fire && (cmd_code == CMD_FREE);
  assign do_probe    = cmd_fire && (cmd_code == CMD_PROBE);
  assign do_uinv     = cmd_fire && (cmd_code == CMD_UINV);
  assign do_insert   = cmd_fire && (cmd_code == CMD_INSERT);
  assign do_delete   = cmd_fire && (cmd_code == CMD_DELETE);

  // addressed set and its ways
  logic [SET_W-1:0]                 key_set;
  logic [IDX_W-1:0]                 at_idx;
  logic [IDX_W-1:0]                 way_idx [NUM_WAYS];
  logic [NUM_WAYS-1:0][DESC_W-1:0]  set_tags;
  logic [NUM_WAYS-1:0]              hit_vec, valid_vec;

  assign key_set = tag_q[PAGE_LSB +: SET_W];
  assign at_idx  = idx_q[IDX_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_set
    assign way_idx[w]  = IDX_W'(lin_index(int'(key_set), w, NUM_WAYS));
    assign set_tags[w] = mem[way_idx[w]].tag;
  end

  swtlb_way_cmp #(.NUM_WAYS(NUM_WAYS)) u_cmp (
    .tags_i  (set_tags),
    .key_i   (tag_q),
    .hit_o   (hit_vec),
    .valid_o (valid_vec)
  );

  logic [WAY_W-1:0] slot_way, hit_way, ins_way;
  logic             set_full, any_hit, multi_hit;

  swtlb_slot_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .valid_i    (valid_vec),
    .hit_i      (hit_vec),
    .rr_i       (rr_q),
    .slot_way_o (slot_way),
    .full_o     (set_full),
    .hit_way_o  (hit_way),
    .any_hit_o  (any_hit)
  );

  assign multi_hit = |(hit_vec & (hit_vec - NUM_WAYS'(1)));
  assign ins_way   = any_hit ? hit_way : slot_way;

  logic rr_step;
  assign rr_step = (do_free && set_full) || (do_insert && !any_hit && set_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      frm_q  <= '0;
      idx_q  <= '0;
      uinv_q <= 1'b0;
      rr_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else begin
      uinv_q <= do_write | do_uinv | do_insert | do_delete;
      if (rr_step) rr_q <= rr_q + WAY_W'(1);

      if (reg_wr_i) begin
        case (reg_sel_i)
          SEL_TAG: tag_q <= reg_wdata_i;
          SEL_FRM: frm_q <= reg_wdata_i;
          SEL_IDX: idx_q <= reg_wdata_i;
          default: ;
        endcase
      end

      if (do_write || do_write_ni) begin
        mem[at_idx] <= '{tag: tag_q, frm: frm_q};
      end

      if (do_read) begin
        tag_q <= mem[at_idx].tag;
        frm_q <= mem[at_idx].frm;
      end

      if (do_probe) begin
        if (!any_hit)      idx_q <= IDX_MISS;
        else if (multi_hit) idx_q <= IDX_DUP;
        else               idx_q <= DESC_W'(way_idx[hit_way]);
      end

      if (do_free) idx_q <= DESC_W'(way_idx[slot_way]);

      if (do_insert) begin
        mem[way_idx[ins_way]] <= '{tag: tag_q, frm: frm_q};
        idx_q <= DESC_W'(way_idx[ins_way]);
      end

      if (do_delete) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (hit_vec[w]) mem[way_idx[w]] <= '0;
        end
      end
    end
  end

  assign tag_desc_o = tag_q;
  assign frm_desc_o = frm_q;
  assign index_o    = idx_q;
  assign uinv_o     = uinv_q;
  assign busy_o     = 1'b0;

  // R2
  probe_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_probe && $countones(hit_vec) == 1) |=>
      (!idx_q[DESC_W-1] && idx_q[IDX_W-1:WAY_W] == $past(key_set)));

  // R3
  probe_miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_probe && hit_vec == '0) |=> (idx_q == IDX_MISS));

  // R4
  probe_dup_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_probe && $countones(hit_vec) > 1) |=> (idx_q == IDX_DUP));

  // R6
  free_slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_free && !(&valid_vec)) |-> !valid_vec[slot_way]);

  // R12
  delete_clears_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_delete |=> (hit_vec == '0));

  // R7
  uinv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uinv_q |-> $past(do_write || do_uinv || do_insert || do_delete));

  // R8
  write_ni_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_write_ni |=> !uinv_q);
endmodule

// File: tb/swtlb_ctrl_tb_top.sv
`timescale 1ns/1ps
module swtlb_ctrl_tb_top;
  localparam int SETS = 128;
  localparam int WAYS = 4;
  localparam int ENT  = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wd = '0;
  logic [31:0] tag_o, frm_o, idx_o;
  logic        uinv_o, busy_o;

  always #2 clk = ~clk;

  swtlb_ctrl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wd),
    .tag_desc_o(tag_o), .frm_desc_o(frm_o), .index_o(idx_o),
    .uinv_o(uinv_o), .busy_o(busy_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R14";

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_tag [ENT];
  logic [31:0] m_frm [ENT];
  logic [31:0] m_tq, m_fq, m_iq;
  int          m_rr;
  bit          m_uinv;

  function automatic bit m_match(logic [31:0] s, logic [31:0] k);
    if (s[10] == 1'b0) return 0;
    if ((s >> 13) != (k >> 13)) return 0;
    return s[8] || (s[7:0] == k[7:0]);
  endfunction

  function automatic int m_pick(int base);
    int r;
    for (int w = 0; w < WAYS; w++) if (!m_tag[base + w][10]) return w;
    r = m_rr;
    m_rr = (m_rr + 1) % WAYS;
    return r;
  endfunction

  task automatic m_cmd(logic [3:0] c);
    int base, at, w;
    int hq[$];
    base = ((m_tq >> 13) % SETS) * WAYS;
    at   = m_iq % ENT;
    for (int k = 0; k < WAYS; k++) if (m_match(m_tag[base + k], m_tq)) hq.push_back(k);
    case (c)
      4'd1: begin m_tag[at] = m_tq; m_frm[at] = m_fq; m_uinv = 1; end
      4'd5: begin m_tag[at] = m_tq; m_frm[at] = m_fq; end
      4'd2: begin m_tq = m_tag[at]; m_fq = m_frm[at]; end
      4'd6: m_uinv = 1;
      4'd4: begin
        if (hq.size() == 0)      m_iq = 32'h8000_0000;
        else if (hq.size() > 1)  m_iq = 32'hC000_0000;
        else                     m_iq = base + hq[0];
      end
      4'd3: m_iq = base + m_pick(base);
      4'd7: begin
        w = (hq.size() > 0) ? hq[0] : m_pick(base);
        m_tag[base + w] = m_tq; m_frm[base + w] = m_fq;
        m_iq = base + w; m_uinv = 1;
      end
      4'd8: begin
        foreach (hq[i]) begin m_tag[base + hq[i]] = '0; m_frm[base + hq[i]] = '0; end
        m_uinv = 1;
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin m_tag[i] = '0; m_frm[i] = '0; end
      m_tq = '0; m_fq = '0; m_iq = '0; m_rr = 0; m_uinv = 0;
    end else begin
      m_uinv = 0;
      if (wr) begin
        case (sel)
          2'd0: m_tq = wd;
          2'd1: m_fq = wd;
          2'd2: m_iq = wd;
          default: m_cmd(wd[3:0]);
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (tag_o !== m_tq || frm_o !== m_fq || idx_o !== m_iq || uinv_o !== m_uinv || busy_o !== 1'b0) begin
        n_fail++;
        $display("FAIL %s model compare: tag %h/%h frm %h/%h idx %h/%h uinv %b/%b busy %b/0",
                 cur_req, tag_o, m_tq, frm_o, m_fq, idx_o, m_iq, uinv_o, m_uinv, busy_o);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk_tag(int vpn, int asid, bit pres, bit glob);
    return (32'(vpn) << 13) | (32'(pres) << 10) | (32'(glob) << 8) | 32'(asid & 255);
  endfunction

  task automatic put(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; sel = s; wd = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 index", idx_o, 32'h0);
    chk("R14 tag", tag_o, 32'h0);
    chk("R14 frame", frm_o, 32'h0);
    chk("R14 strobe", 32'(uinv_o), 32'h0);
    chk("R13 busy", 32'(busy_o), 32'h0);

    // R1 / R7: write at set 5 way 2 (index 22), strobe follows
    cur_req = "R7";
    put(2'd0, mk_tag(5, 8'h11, 1, 0));
    put(2'd1, 32'hABCD_0007);
    put(2'd2, 32'd22);
    put(2'd3, 32'd1);
    chk("R7 strobe after write", 32'(uinv_o), 32'h1);
    cur_req = "R2";
    put(2'd3, 32'd4);
    chk("R1 R2 probe index", idx_o, 32'd22);

    // R3 miss on other ASID
    cur_req = "R3";
    put(2'd0, mk_tag(5, 8'h12, 1, 0));
    put(2'd3, 32'd4);
    chk("R3 probe miss", idx_o, 32'h8000_0000);

    // R5 / R8 global entry at set 6 way 0 via quiet write
    cur_req = "R8";
    put(2'd0, mk_tag(6, 8'h30, 1, 1));
    put(2'd2, 32'd24);
    put(2'd3, 32'd5);
    chk("R8 no strobe", 32'(uinv_o), 32'h0);
    cur_req = "R5";
    put(2'd0, mk_tag(6, 8'h77, 1, 0));
    put(2'd3, 32'd4);
    chk("R5 global ignores ASID", idx_o, 32'd24);

    // R4 duplicate: same tag in set 5 way 1
    cur_req = "R4";
    put(2'd0, mk_tag(5, 8'h11, 1, 0));
    put(2'd2, 32'd21);
    put(2'd3, 32'd5);
    put(2'd3, 32'd4);
    chk("R4 duplicate code", idx_o, 32'hC000_0000);

    // R12 delete both copies
    cur_req = "R12";
    put(2'd3, 32'd8);
    chk("R12 strobe", 32'(uinv_o), 32'h1);
    chk("R12 index unchanged", idx_o, 32'hC000_0000);
    put(2'd3, 32'd4);
    chk("R12 probe after delete", idx_o, 32'h8000_0000);

    // R6 free slot in empty set 9
    cur_req = "R6";
    put(2'd0, mk_tag(9, 1, 1, 0));
    put(2'd3, 32'd3);
    chk("R6 first free", idx_o, 32'd36);

    // R11 fill set 9 by insert
    cur_req = "R11";
    for (int k = 0; k < 4; k++) begin
      put(2'd0, mk_tag(9 + 128 * k, 1, 1, 0));
      put(2'd1, 32'h1000 + 32'(k));
      put(2'd3, 32'd7);
      chk("R11 insert slot", idx_o, 32'd36 + 32'(k));
    end
    put(2'd0, mk_tag(9, 1, 1, 0));
    put(2'd1, 32'h2222);
    put(2'd3, 32'd7);
    chk("R11 overwrite match", idx_o, 32'd36);
    chk("R11 strobe", 32'(uinv_o), 32'h1);
    put(2'd0, mk_tag(9 + 128 * 4, 1, 1, 0));
    put(2'd3, 32'd7);
    chk("R6 R11 evict rr way0", idx_o, 32'd36);
    cur_req = "R6";
    put(2'd3, 32'd3);
    chk("R6 full set rr way1", idx_o, 32'd37);

    // R10 read back
    cur_req = "R10";
    put(2'd2, 32'd37);
    put(2'd3, 32'd2);
    chk("R10 read tag", tag_o, mk_tag(137, 1, 1, 0));
    chk("R10 read frame", frm_o, 32'h1001);

    // R9 invalidate alone, R13 unknown code
    cur_req = "R9";
    put(2'd3, 32'd6);
    chk("R9 strobe", 32'(uinv_o), 32'h1);
    chk("R9 tag kept", tag_o, mk_tag(137, 1, 1, 0));
    cur_req = "R13";
    put(2'd3, 32'd15);
    chk("R13 unknown no strobe", 32'(uinv_o), 32'h0);
    chk("R13 unknown index kept", idx_o, 32'd37);

    // R7 blanking with zero pair at index 24
    cur_req = "R7";
    put(2'd0, 32'h0);
    put(2'd1, 32'h0);
    put(2'd2, 32'd24);
    put(2'd3, 32'd1);
    put(2'd0, mk_tag(6, 8'h77, 1, 0));
    put(2'd3, 32'd4);
    chk("R7 blanked slot misses", idx_o, 32'h8000_0000);

    // random phase on a crowded set, model compared every clock
    cur_req = "R5 random";
    for (int n = 0; n < 800; n++) begin
      int s;
      int vpns[6];
      logic [31:0] d;
      vpns = '{3, 131, 259, 387, 515, 67};
      s = $urandom % 4;
      case (s)
        0: d = mk_tag(vpns[$urandom % 6], 1 + ($urandom % 2), ($urandom % 10) != 0, ($urandom % 5) == 0);
        1: d = $urandom;
        2: d = (($urandom % 2) != 0) ? 32'(12 + $urandom % 4) : 32'(268 + $urandom % 4);
        default: d = 32'($urandom % 16);
      endcase
      put(2'(s), d);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule